// File: doc/BRIEF.md
# ADC Fast Overrange Detect Logic

This block sits beside the sample output of a pipelined ADC. It drives four fast level-indicator bits that an external gain-control loop uses to back off the gain before the converter clips. Each clock it receives one signed 14-bit sample and the 4-bit coarse level code from the converter's first stage. From these it derives a sign-independent magnitude, a full-scale overflow flag, and three threshold flags. A 3-bit mode field decides which of these values appear on the four output bits.

Static configuration inputs set the mode, an enable, an upper and a lower fine threshold on the magnitude, and a threshold on the coarse code. The whole 4-bit result word passes through one delay line. That line can be tapped at either a short latency (2 cycles) or a long latency (6 cycles), so every output bit stays aligned with the others.

Top module: `fast_level_monitor`

## Requirements
- R1: While rst_n is low at a rising clock edge, the delay line is cleared. After that edge fd_o reads 0000 until new results reach the selected tap.
- R2: The magnitude is |sample|, taking the sample as two's complement. The code -8192 saturates to 8191. A positive and a negative sample of the same size give the same output word.
- R3: The overflow flag is 1 exactly when the magnitude equals 8191, that is, for samples +8191, -8191 and -8192.
- R4: The upper fine flag is 1 when the magnitude is strictly greater than hi_thr_i, and 0 otherwise.
- R5: The lower fine flag is 1 when the magnitude is strictly less than lo_thr_i. The gain-increase indication equals this flag.
- R6: Coarse codes above 8 are clamped to 8. The coarse upper flag is 1 when the clamped code is strictly greater than coarse_thr_i. The gain-decrease indication equals the upper fine flag.
- R7: Mode 000 puts the clamped coarse code on fd_o[3:0].
- R8: Mode 001 gives {code[3:1], overflow}. Mode 010 gives {code[3:2], overflow, lower}. Mode 011 gives {code[3], coarse-upper, overflow, lower}.
- R9: Mode 100 gives {overflow, coarse-upper, upper, lower}. Mode 101 gives {overflow, upper, gain-increase, gain-decrease}.
- R10: Modes 110 and 111 produce 0000.
- R11: With enable_i low, the word entering the delay line is 0000, whatever the other inputs are.
- R12: With long_lat_i low, fd_o shows the word for the inputs sampled 2 rising edges earlier. With long_lat_i high, it shows the word from 6 edges earlier. All four bits take the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 14 | Two's-complement converter sample |
| coarse_i | input | 4 | Early-stage coarse level code |
| mode_i | input | 3 | Output assignment select |
| enable_i | input | 1 | Output enable; low forces zero words |
| long_lat_i | input | 1 | 1 selects the 6-cycle tap, 0 the 2-cycle tap |
| hi_thr_i | input | 13 | Upper fine magnitude threshold |
| lo_thr_i | input | 13 | Lower fine magnitude threshold |
| coarse_thr_i | input | 4 | Coarse code threshold |
| fd_o | output | 4 | Fast-detect output bits |

## Verification
A full-scale sample can raise the overflow flag and the upper fine flag in the same cycle. In mode 101 that same cycle can also drive the gain-decrease bit, since it follows the upper fine flag. The bench provokes this overlap with directed samples of +8191, -8191 and -8192 while the upper threshold lies below full scale, and it also weights its random samples toward these codes. It then compares the complete 4-bit word, at the selected latency, against a model. So a collision that drops or shifts one flag shows up as a miscompare in that exact word.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
// fld_pkg: shared types for the fast level monitor.
// Assumes a 4-bit coarse code and a 4-bit output word.
package fld_pkg;
    localparam int FD_W   = 4;
    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        MODE_MAG          = 3'b000,
        MODE_MAG3_OVR     = 3'b001,
        MODE_MAG2_OVR_LO  = 3'b010,
        MODE_MAG1_CUP     = 3'b011,
        MODE_FLAGS        = 3'b100,
        MODE_GAIN         = 3'b101
    } fd_mode_e;

    typedef struct packed {
        logic ovr;
        logic c_up;
        logic f_up;
        logic f_low;
    } level_flags_t;
endpackage

// File: rtl/fld_magnitude.sv
`timescale 1ns/1ps
// fld_magnitude: absolute value of a two's-complement sample.
// The most negative code saturates to the largest positive magnitude,
// so the result always fits in DATA_W-1 bits. Purely combinational.
module fld_magnitude #(
    parameter int DATA_W = 14,
    localparam int MAG_W = DATA_W - 1
) (
    input  logic [DATA_W-1:0] sample,
    output logic [MAG_W-1:0]  mag
);
    logic [DATA_W-1:0] abs_full;

    // Negate negative samples, then saturate the one code that overflows.
    always_comb begin
        abs_full = sample[DATA_W-1] ? (~sample + 1'b1) : sample;
        mag      = abs_full[DATA_W-1] ? {MAG_W{1'b1}} : abs_full[MAG_W-1:0];
    end
endmodule

// File: rtl/fld_compare.sv
`timescale 1ns/1ps
// fld_compare: derives level flags from the magnitude and coarse code.
// Assumes thresholds are static or change slowly; strict compares.
module fld_compare
    import fld_pkg::*;
#(
    parameter int MAG_W = 13
) (
    input  logic [MAG_W-1:0]  mag,
    input  logic [CODE_W-1:0] coarse,
    input  logic [MAG_W-1:0]  hi_thr,
    input  logic [MAG_W-1:0]  lo_thr,
    input  logic [CODE_W-1:0] coarse_thr,
    output level_flags_t      flags,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(1) << (CODE_W - 1);

    // Clamp the coarse code to its top legal level.
    always_comb code = (coarse > CODE_MAX) ? CODE_MAX : coarse;

    // Threshold and full-scale decisions on the sign-free magnitude.
    always_comb begin
        flags.ovr   = &mag;
        flags.f_up  = mag > hi_thr;
        flags.f_low = mag < lo_thr;
        flags.c_up  = code > coarse_thr;
    end
endmodule

// File: rtl/fld_mode_mux.sv
`timescale 1ns/1ps
// fld_mode_mux: places coarse code bits and flags on the four outputs
// according to the mode field. Reserved modes yield an all-zero word.
module fld_mode_mux
    import fld_pkg::*;
(
    input  logic [2:0]        mode,
    input  logic [CODE_W-1:0] code,
    input  level_flags_t      flags,
    output logic [FD_W-1:0]   word
);
    // Select the bit assignment for the current mode.
    always_comb begin
        case (mode)
            MODE_MAG:         word = code;
            MODE_MAG3_OVR:    word = {code[3:1], flags.ovr};
            MODE_MAG2_OVR_LO: word = {code[3:2], flags.ovr, flags.f_low};
            MODE_MAG1_CUP:    word = {code[3], flags.c_up, flags.ovr, flags.f_low};
            MODE_FLAGS:       word = {flags.ovr, flags.c_up, flags.f_up, flags.f_low};
            MODE_GAIN:        word = {flags.ovr, flags.f_up, flags.f_low, flags.f_up};
            default:          word = '0;
        endcase
    end
endmodule

// File: rtl/fld_delay_line.sv
`timescale 1ns/1ps
// fld_delay_line: shift register with two selectable taps.
// Assumes 1 <= SHORT_LAT <= LONG_LAT. Synchronous active-low reset.
module fld_delay_line #(
    parameter int W         = 4,
    parameter int SHORT_LAT = 2,
    parameter int LONG_LAT  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         long_sel,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [LONG_LAT];

    // Shift the word one stage per clock; clear every stage on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LONG_LAT; k++) stage[k] <= '0;
        end else begin
            stage[0] <= d;
            for (int k = 1; k < LONG_LAT; k++) stage[k] <= stage[k-1];
        end
    end

    // Pick the output tap.
    assign q = long_sel ? stage[LONG_LAT-1] : stage[SHORT_LAT-1];
endmodule

// File: rtl/fast_level_monitor.sv
`timescale 1ns/1ps
// fast_level_monitor: fast overrange detect for an ADC sample stream.
// Computes a magnitude, level flags and a mode-dependent output word,
// then delays it by 2 or 6 cycles. Assumes configuration inputs change
// only between bursts of interest; they are sampled like the data.
module fast_level_monitor
    import fld_pkg::*;
#(
    parameter int DATA_W    = 14,
    parameter int SHORT_LAT = 2,
    parameter int LONG_LAT  = 6,
    localparam int MAG_W    = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [CODE_W-1:0] coarse_i,
    input  logic [2:0]        mode_i,
    input  logic              enable_i,
    input  logic              long_lat_i,
    input  logic [MAG_W-1:0]  hi_thr_i,
    input  logic [MAG_W-1:0]  lo_thr_i,
    input  logic [CODE_W-1:0] coarse_thr_i,
    output logic [FD_W-1:0]   fd_o
);
    logic [MAG_W-1:0]  mag;
    logic [CODE_W-1:0] code;
    level_flags_t      flags;
    logic [FD_W-1:0]   mux_word;
    logic [FD_W-1:0]   line_in;
    logic              ovr_flag;

    fld_magnitude #(.DATA_W(DATA_W)) u_mag (
        .sample (sample_i),
        .mag    (mag)
    );

    fld_compare #(.MAG_W(MAG_W)) u_cmp (
        .mag        (mag),
        .coarse     (coarse_i),
        .hi_thr     (hi_thr_i),
        .lo_thr     (lo_thr_i),
        .coarse_thr (coarse_thr_i),
        .flags      (flags),
        .code       (code)
    );

    fld_mode_mux u_mux (
        .mode  (mode_i),
        .code  (code),
        .flags (flags),
        .word  (mux_word)
    );

    // Blank the word before it enters the delay line when disabled.
    assign line_in  = enable_i ? mux_word : '0;
    assign ovr_flag = flags.ovr;

    fld_delay_line #(
        .W         (FD_W),
        .SHORT_LAT (SHORT_LAT),
        .LONG_LAT  (LONG_LAT)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .long_sel (long_lat_i),
        .d        (line_in),
        .q        (fd_o)
    );
endmodule

// File: rtl/fld_checker.sv
`timescale 1ns/1ps
// fld_checker: temporal properties of fast_level_monitor, bound below.
module fld_checker #(
    parameter int DATA_W    = 14,
    parameter int SHORT_LAT = 2,
    parameter int LONG_LAT  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] sample_i,
    input logic [2:0]        mode_i,
    input logic              enable_i,
    input logic              long_lat_i,
    input logic              ovr_flag,
    input logic [3:0]        line_in,
    input logic [3:0]        fd_o
);
    localparam int CNT_W = $clog2(LONG_LAT + 1) + 1;
    localparam logic [DATA_W-1:0] POS_FS  = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_FS  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] NEG_FS1 = {1'b1, {(DATA_W-2){1'b0}}, 1'b1};

    logic [CNT_W-1:0] since_rst;

    // Count edges since reset release, saturating past the long tap.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst <= CNT_W'(LONG_LAT)) since_rst <= since_rst + 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> fd_o == 4'b0000); // R1

    AST_OVR_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag == (sample_i == POS_FS || sample_i == NEG_FS || sample_i == NEG_FS1)); // R3

    AST_SHORT_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= CNT_W'(SHORT_LAT) && !long_lat_i) |-> fd_o == $past(line_in, SHORT_LAT)); // R12

    AST_LONG_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= CNT_W'(LONG_LAT) && long_lat_i) |-> fd_o == $past(line_in, LONG_LAT)); // R12

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= CNT_W'(SHORT_LAT) && !long_lat_i && $past(!enable_i, SHORT_LAT))
        |-> fd_o == 4'b0000); // R11

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= CNT_W'(SHORT_LAT) && !long_lat_i && $past(mode_i[2] & mode_i[1], SHORT_LAT))
        |-> fd_o == 4'b0000); // R10
endmodule

bind fast_level_monitor fld_checker #(
    .DATA_W    (DATA_W),
    .SHORT_LAT (SHORT_LAT),
    .LONG_LAT  (LONG_LAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   (sample_i),
    .mode_i     (mode_i),
    .enable_i   (enable_i),
    .long_lat_i (long_lat_i),
    .ovr_flag   (ovr_flag),
    .line_in    (line_in),
    .fd_o       (fd_o)
);

// File: tb/tb_fast_level_monitor.sv
`timescale 1ns/1ps
// tb_fast_level_monitor: random plus directed stimulus against a model.
module tb_fast_level_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] sample_i = '0;
    logic [3:0]  coarse_i = '0;
    logic [2:0]  mode_i = '0;
    logic        enable_i = 1'b0;
    logic        long_lat_i = 1'b0;
    logic [12:0] hi_thr_i = '0;
    logic [12:0] lo_thr_i = '0;
    logic [3:0]  coarse_thr_i = '0;
    logic [3:0]  fd_o;

    int vectors = 0;
    int misses = 0;
    int idx = 0;
    int lat = 2;
    logic [3:0] hist [0:2047];
    logic [2:0] mode_hist [0:2047];
    logic       en_hist [0:2047];

    fast_level_monitor dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .coarse_i(coarse_i),
        .mode_i(mode_i), .enable_i(enable_i), .long_lat_i(long_lat_i),
        .hi_thr_i(hi_thr_i), .lo_thr_i(lo_thr_i), .coarse_thr_i(coarse_thr_i),
        .fd_o(fd_o)
    );

    always #4 clk = ~clk;

    // Reference word from the requirements.
    function automatic logic [3:0] model(logic [13:0] s, logic [3:0] c, logic [2:0] m,
                                         logic en, logic [12:0] ut, logic [12:0] lt,
                                         logic [3:0] ct);
        int sv = $signed(s);
        int mg = (sv < 0) ? -sv : sv;       // R2 sign-free magnitude
        logic ov, fu, fl, cu;
        logic [3:0] cc;
        if (mg > 8191) mg = 8191;           // R2 saturation of -8192
        ov = (mg == 8191);                  // R3
        fu = (mg > int'(ut));               // R4
        fl = (mg < int'(lt));               // R5
        cc = (c > 4'd8) ? 4'd8 : c;         // R6 clamp
        cu = (cc > ct);                     // R6 coarse flag
        if (!en) return 4'b0000;
        case (m)
            3'd0: return cc;
            3'd1: return {cc[3:1], ov};
            3'd2: return {cc[3:2], ov, fl};
            3'd3: return {cc[3], cu, ov, fl};
            3'd4: return {ov, cu, fu, fl};
            3'd5: return {ov, fu, fl, fu};
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] m, logic en);
        if (!en) return "R11";
        if (m == 3'd0) return "R7";
        if (m <= 3'd3) return "R8";
        if (m <= 3'd5) return "R9";
        return "R10";
    endfunction

    // Check the output due now, then drive one vector and advance.
    task automatic apply(logic [13:0] s, logic [3:0] c, logic [2:0] m, logic en);
        logic [3:0] exp_w;
        string t;
        exp_w = (idx >= lat) ? hist[idx-lat] : 4'b0000;
        t = (idx >= lat) ? tag_of(mode_hist[idx-lat], en_hist[idx-lat]) : "R1";
        vectors++;
        if (fd_o !== exp_w) begin
            misses++;
            $display("FAIL %s (R12 latency %0d) vec %0d: got %b expected %b", t, lat, idx, fd_o, exp_w);
        end
        sample_i = s; coarse_i = c; mode_i = m; enable_i = en;
        hist[idx] = model(s, c, m, en, hi_thr_i, lo_thr_i, coarse_thr_i);
        mode_hist[idx] = m; en_hist[idx] = en;
        idx++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idx = 0;
        vectors++;
        if (fd_o !== 4'b0000) begin
            misses++;
            $display("FAIL R1 after reset: got %b expected 0000", fd_o);
        end
    endtask

    task automatic run_phase(logic long_sel);
        long_lat_i = long_sel;
        lat = long_sel ? 6 : 2;
        do_reset();
        hi_thr_i = 13'd6000; lo_thr_i = 13'd100; coarse_thr_i = 4'd5;
        // Directed corners: full scale both signs (R2, R3, R4 overlap).
        apply(14'h1FFF, 4'd8, 3'd4, 1'b1);
        apply(14'h2000, 4'd8, 3'd4, 1'b1);
        apply(14'h2001, 4'd8, 3'd5, 1'b1);
        apply(14'h1FFF, 4'd8, 3'd5, 1'b1);
        // Threshold edges (R4, R5): equal is not beyond.
        apply(14'd6000, 4'd3, 3'd4, 1'b1);
        apply(14'd6001, 4'd3, 3'd4, 1'b1);
        apply(-14'sd6001, 4'd3, 3'd4, 1'b1);
        apply(14'd100, 4'd1, 3'd5, 1'b1);
        apply(14'd99, 4'd1, 3'd5, 1'b1);
        // Coarse clamp and coarse flag (R6, R7).
        apply(14'd0, 4'd15, 3'd0, 1'b1);
        apply(14'd0, 4'd6, 3'd3, 1'b1);
        apply(14'd0, 4'd5, 3'd3, 1'b1);
        // Reserved modes (R10) and disable (R11).
        apply(14'h1FFF, 4'd8, 3'd6, 1'b1);
        apply(14'h2000, 4'd8, 3'd7, 1'b1);
        apply(14'h1FFF, 4'd8, 3'd4, 1'b0);
        // Random body.
        for (int n = 0; n < 1500; n++) begin
            logic [13:0] s;
            int pick;
            if (n % 64 == 63) begin
                hi_thr_i = 13'($urandom);
                lo_thr_i = 13'($urandom);
                coarse_thr_i = 4'($urandom % 9);
            end
            pick = $urandom % 10;
            case (pick)
                0: s = 14'h1FFF;
                1: s = 14'h2000;
                2: s = 14'h2001;
                3: s = {1'b0, hi_thr_i};
                4: s = 14'(-int'(hi_thr_i) - 1);
                5: s = 14'(int'(lo_thr_i) - 1);
                6: s = 14'(-int'(lo_thr_i));
                default: s = 14'($urandom);
            endcase
            apply(s, 4'($urandom), 3'($urandom), ($urandom % 8) != 0);
        end
        // Flush the tail with disabled words.
        for (int n = 0; n < 8; n++) apply(14'd0, 4'd0, 3'd0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        run_phase(1'b0);
        run_phase(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #800000;
        misses++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule